// File: doc/BRIEF.md
# Serial Link MAC-End Transceiver

This block sits at the MAC end of a two-device, full-duplex serial link. The PHY at the far end supplies two clocks that run all the time, one for transmit and one for receive. The block never drives a clock. On transmit it takes bytes from a valid/ready stream in the transmit clock domain. It shifts each byte out least significant bit first and raises a frame enable for as long as bytes keep coming. On receive it samples serial data and an enable on the receive clock and rebuilds bytes. It marks the last byte of each frame and flags a trailing partial byte as an error. Each entry then crosses into the system clock domain through a small asynchronous FIFO.

Two sidebands have no timing relation to either link clock. The first is a busy line. A static configuration input sets its direction: as an input it stops new transmit frames from starting, and as an output it reports a full receive FIFO. The second is a collision line from the PHY. It also holds back new frames and is kept as a sticky status bit in the system domain. Each sideband passes through a two-flop synchroniser in every domain that uses it.

Top module: `gpsi_mac_xcvr`

## Requirements
- R1: After reset `ser_txen`, `ser_txd`, `rx_valid`, `busy_out` and `col_sticky` are 0, and `tx_ready` is 1 while both sidebands are low.
- R2: A byte accepted at a `tx_clk` edge (`tx_valid` and `tx_ready` both high) appears on `ser_txd` over the next eight `tx_clk` cycles, least significant bit first. `ser_txen` is high in the first of these cycles.
- R3: `tx_ready` rises during the eighth bit of a byte. A byte accepted then follows with no gap and `ser_txen` stays high. When no byte is offered, `ser_txen` drops after that bit.
- R4: With `busy_is_out` = 0 and `busy_in` high (after two `tx_clk` of synchronisation), `tx_ready` is 0 while idle and no frame starts. A frame starts once the line falls.
- R5: A rise of `busy_in` while a frame is in progress does not cut it short. Every byte offered back to back is still sent.
- R6: With `busy_is_out` = 1 the `busy_in` input has no effect on transmit, and `busy_oe` equals `busy_is_out`.
- R7: Once `col_in` is high for two `sys_clk` cycles, `col_sticky` is set. It stays set after `col_in` falls until `col_clr` is pulsed, and a set takes priority over a clear.
- R8: While the synchronised `col_in` is high, `tx_ready` is 0 while idle and no frame starts.
- R9: Receive bits are sampled on `rx_clk` while `ser_rxen` is high and assembled least significant bit first. Each full byte becomes one FIFO entry (`rx_data`, `rx_last`, `rx_err`). The final byte of a frame carries `rx_last` = 1.
- R10: If `ser_rxen` falls after 1 to 7 bits of a byte, those bits are dropped and one entry with `rx_data` = 0, `rx_last` = 1 and `rx_err` = 1 ends the frame.
- R11: With `busy_is_out` = 1, `busy_out` is high while the 8-entry FIFO is full and falls once space is free. Entries written while the FIFO is full are discarded.
- R12: Entries leave the FIFO in arrival order, across frame boundaries, one per `sys_clk` with `rx_valid` and `rx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the receive FIFO read side and collision status |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| busy_is_out | input | 1 | Static config: 1 = busy line is an output, 0 = input |
| tx_clk | input | 1 | Transmit clock from the PHY |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts `tx_data` at this edge |
| ser_txd | output | 1 | Serial transmit data |
| ser_txen | output | 1 | Transmit frame enable |
| rx_clk | input | 1 | Receive clock from the PHY |
| ser_rxd | input | 1 | Serial receive data |
| ser_rxen | input | 1 | Receive frame enable |
| rx_data | output | 8 | Received byte at FIFO head |
| rx_valid | output | 1 | FIFO head holds an entry |
| rx_ready | input | 1 | Pop the FIFO head |
| rx_last | output | 1 | Head entry ends a frame |
| rx_err | output | 1 | Head entry marks a dropped partial byte |
| busy_in | input | 1 | Far-end busy, asynchronous |
| busy_out | output | 1 | Local busy (FIFO full), valid when `busy_oe` is 1 |
| busy_oe | output | 1 | Output enable for the busy line |
| col_in | input | 1 | Collision from the PHY, asynchronous |
| col_clr | input | 1 | Clears the sticky collision bit |
| col_sticky | output | 1 | Sticky collision status |

## Verification
Transmit results are due one `tx_clk` after the accepting edge, and one bit follows per cycle after that. The bench captures `ser_txd` and `ser_txen` on every falling `tx_clk` edge and compares the whole bit stream after the frame ends. Sideband effects take two cycles of the domain that uses them, so the bench waits four cycles before sampling `tx_ready` or `col_sticky`. Receive entries take one `rx_clk` to be written and then two `sys_clk` for the pointer crossing, so the bench polls `rx_valid` on falling `sys_clk` edges with a bounded wait. It checks `busy_out` only after six `rx_clk` cycles have passed.

// File: rtl/gpsi_mac_xcvr.sv
`timescale 1ns/1ps
module gpsi_mac_xcvr #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          busy_is_out,
  input  logic          tx_clk,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          ser_txd,
  output logic          ser_txen,
  input  logic          rx_clk,
  input  logic          ser_rxd,
  input  logic          ser_rxen,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          rx_last,
  output logic          rx_err,
  input  logic          busy_in,
  output logic          busy_out,
  output logic          busy_oe,
  input  logic          col_in,
  input  logic          col_clr,
  output logic          col_sticky
);
  localparam int CW    = (DW > 1) ? $clog2(DW) : 1;
  localparam int EW    = DW + 2;
  localparam int DEPTH = 1 << AW;

  // ---------------- transmit domain ----------------
  logic [1:0]    tbusy_s, tcol_s;
  logic [DW-1:0] tsh;
  logic [CW-1:0] tcnt;
  logic          tact;

  always_ff @(posedge tx_clk or negedge rst_n)
    if (!rst_n) begin
      tbusy_s <= '0;
      tcol_s  <= '0;
    end else begin
      tbusy_s <= {tbusy_s[0], busy_in};
      tcol_s  <= {tcol_s[0], col_in};
    end

  wire tx_gate   = (tbusy_s[1] & ~busy_is_out) | tcol_s[1];
  wire tlast_bit = (tcnt == CW'(DW-1));
  assign tx_ready = tact ? tlast_bit : ~tx_gate;
  wire tload     = tx_valid & tx_ready;

  always_ff @(posedge tx_clk or negedge rst_n)
    if (!rst_n) begin
      tsh  <= '0;
      tcnt <= '0;
      tact <= 1'b0;
    end else if (tload) begin
      tsh  <= tx_data;
      tcnt <= '0;
      tact <= 1'b1;
    end else if (tact) begin
      if (tlast_bit) tact <= 1'b0;
      else begin
        tsh  <= tsh >> 1;
        tcnt <= tcnt + CW'(1);
      end
    end

  assign ser_txd  = tact & tsh[0];
  assign ser_txen = tact;

  AST_TX_HOLD: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tact && !tlast_bit |=> ser_txen); // R3
  AST_TX_NO_START: assert property (@(posedge tx_clk) disable iff (!rst_n)
    !tact && tx_gate |=> !ser_txen); // R4

  // ---------------- receive domain ----------------
  logic [DW-2:0] rsh;
  logic [CW-1:0] rcnt;
  logic [DW-1:0] hold;
  logic          hold_v, rin_frame;
  logic          wpush;
  logic [EW-1:0] wdin;
  logic [AW:0]   wbin, wgray, wbin_nx;
  logic [AW:0]   rq1, rq2;
  logic          wfull, rbusy;
  logic [EW-1:0] mem [DEPTH];

  wire rbyte_done = ser_rxen & (rcnt == CW'(DW-1));

  always_comb begin
    wpush = 1'b0;
    wdin  = '0;
    if (ser_rxen && hold_v) begin
      wpush = 1'b1;
      wdin  = {hold, 2'b00};
    end else if (!ser_rxen && rin_frame) begin
      wpush = 1'b1;
      if (rcnt != '0) wdin = {{DW{1'b0}}, 2'b11};
      else            wdin = {hold, 2'b10};
    end
  end

  always_ff @(posedge rx_clk or negedge rst_n)
    if (!rst_n) begin
      rsh       <= '0;
      rcnt      <= '0;
      hold      <= '0;
      hold_v    <= 1'b0;
      rin_frame <= 1'b0;
    end else begin
      rin_frame <= ser_rxen;
      if (ser_rxen) begin
        if (rbyte_done) begin
          hold <= {ser_rxd, rsh};
          rcnt <= '0;
        end else begin
          rsh  <= {ser_rxd, rsh[DW-2:1]};
          rcnt <= rcnt + CW'(1);
        end
      end else
        rcnt <= '0;
      if (rbyte_done)  hold_v <= 1'b1;
      else if (wpush)  hold_v <= 1'b0;
    end

  assign wfull   = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign wbin_nx = wbin + (AW+1)'(1);
  wire   wr_do   = wpush & ~wfull;

  always_ff @(posedge rx_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      rbusy <= 1'b0;
    end else begin
      rq1   <= rgray;
      rq2   <= rq1;
      rbusy <= wfull;
      if (wr_do) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge rx_clk)
    if (wr_do) mem[wbin[AW-1:0]] <= wdin;

  assign busy_out = busy_is_out & rbusy;
  assign busy_oe  = busy_is_out;

  AST_ERR_LAST: assert property (@(posedge rx_clk) disable iff (!rst_n)
    wpush && wdin[0] |-> wdin[1]); // R10
  AST_FULL_DROP: assert property (@(posedge rx_clk) disable iff (!rst_n)
    wpush && wfull |=> $stable(wbin)); // R11

  // ---------------- system domain ----------------
  logic [AW:0]   rbin, rgray, rbin_nx, wq1, wq2;
  logic [1:0]    scol_s;
  logic [EW-1:0] head;

  assign rx_valid = (rgray != wq2);
  assign head     = mem[rbin[AW-1:0]];
  assign rx_data  = head[EW-1:2];
  assign rx_last  = head[1];
  assign rx_err   = head[0];
  assign rbin_nx  = rbin + (AW+1)'(1);

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      rbin       <= '0;
      rgray      <= '0;
      wq1        <= '0;
      wq2        <= '0;
      scol_s     <= '0;
      col_sticky <= 1'b0;
    end else begin
      wq1        <= wgray;
      wq2        <= wq1;
      scol_s     <= {scol_s[0], col_in};
      col_sticky <= scol_s[1] | (col_sticky & ~col_clr);
      if (rx_valid && rx_ready) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end

  AST_COL_STICKY: assert property (@(posedge sys_clk) disable iff (!rst_n)
    scol_s[1] |=> col_sticky); // R7
  AST_POP_ORDER: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> rbin == $past(rbin) + (AW+1)'(1)); // R12
endmodule

// File: tb/gpsi_mac_xcvr_bench.sv
`timescale 1ns/1ps
module gpsi_mac_xcvr_bench;
  logic sys_clk = 0, tx_clk = 0, rx_clk = 0, rst_n = 0;
  logic busy_is_out = 0, tx_valid = 0, ser_rxd = 0, ser_rxen = 0;
  logic rx_ready = 0, busy_in = 0, col_in = 0, col_clr = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, ser_txd, ser_txen, rx_valid, rx_last, rx_err;
  logic busy_out, busy_oe, col_sticky;
  logic [7:0] rx_data;

  always #2.5 sys_clk = ~sys_clk;
  always #6   tx_clk  = ~tx_clk;
  always #7   rx_clk  = ~rx_clk;

  gpsi_mac_xcvr u_gpsi_mac_xcvr (
    .sys_clk, .rst_n, .busy_is_out, .tx_clk, .tx_data, .tx_valid, .tx_ready,
    .ser_txd, .ser_txen, .rx_clk, .ser_rxd, .ser_rxen, .rx_data, .rx_valid,
    .rx_ready, .rx_last, .rx_err, .busy_in, .busy_out, .busy_oe, .col_in,
    .col_clr, .col_sticky);

  int tests = 0, failed = 0;
  bit done = 0;
  logic [7:0] txq [8];
  logic [7:0] rxq [12];
  logic cap [64];
  int cap_n = 0, en_falls = 0;
  logic prev_en = 0;

  always @(negedge tx_clk) begin
    if (ser_txen && cap_n < 64) begin cap[cap_n] = ser_txd; cap_n++; end
    if (prev_en && !ser_txen) en_falls++;
    prev_en = ser_txen;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input int n, input bit busy_mid);
    cap_n = 0; en_falls = 0;
    @(negedge tx_clk);
    for (int i = 0; i < n; i++) begin
      tx_valid = 1; tx_data = txq[i];
      #1;
      while (!tx_ready) begin @(negedge tx_clk); #1; end
      @(posedge tx_clk);
      @(negedge tx_clk);
      if (i == 0) chk(ser_txen && ser_txd == txq[0][0], "R2 first bit",
                      {ser_txen, ser_txd}, {1'b1, txq[0][0]});
      if (busy_mid && i == 0) busy_in = 1;
    end
    tx_valid = 0;
    repeat (12) @(negedge tx_clk);
  endtask

  task automatic check_tx(input int n, input string req);
    int bad = 0;
    chk(cap_n == 8*n, req, cap_n, 8*n);
    for (int i = 0; i < 8*n && i < cap_n; i++)
      if (cap[i] !== txq[i/8][i%8]) bad++;
    chk(bad == 0, req, bad, 0);
    chk(en_falls == 1, req, en_falls, 1);
  endtask

  task automatic rx_send(input int n, input int partial);
    @(negedge rx_clk);
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        ser_rxen = 1; ser_rxd = rxq[i][b];
        @(negedge rx_clk);
      end
    for (int b = 0; b < partial; b++) begin
      ser_rxen = 1; ser_rxd = 1;
      @(negedge rx_clk);
    end
    ser_rxen = 0; ser_rxd = 0;
    repeat (3) @(negedge rx_clk);
  endtask

  task automatic pop_check(input logic [7:0] d, input bit l, input bit e, input string req);
    int w = 0;
    @(negedge sys_clk);
    while (!rx_valid && w < 200) begin @(negedge sys_clk); w++; end
    chk(rx_valid && rx_data == d && rx_last == l && rx_err == e, req,
        {rx_valid, rx_last, rx_err, rx_data}, {1'b1, l, e, d});
    rx_ready = 1;
    @(negedge sys_clk);
    rx_ready = 0;
  endtask

  task automatic t_reset_state;
    chk(!ser_txen && !ser_txd, "R1 tx idle", {ser_txen, ser_txd}, 0);
    chk(!rx_valid && !busy_out && !col_sticky, "R1 rx/status",
        {rx_valid, busy_out, col_sticky}, 0);
    chk(tx_ready, "R1 tx_ready", tx_ready, 1);
  endtask

  task automatic t_tx_basic;
    txq[0] = 8'hA5;
    send_tx(1, 0);
    check_tx(1, "R2 single byte");
    txq[0] = 8'h3C; txq[1] = 8'h81; txq[2] = 8'h7E;
    send_tx(3, 0);
    check_tx(3, "R3 chained bytes");
    chk(!ser_txen, "R3 enable drops", ser_txen, 0);
  endtask

  task automatic t_tx_busy_gate;
    busy_in = 1;
    repeat (4) @(negedge tx_clk);
    tx_valid = 1; tx_data = 8'h55;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge tx_clk);
        if (tx_ready || ser_txen) seen++;
      end
      chk(seen == 0, "R4 no start while busy", seen, 0);
    end
    busy_in = 0;
    txq[0] = 8'h55;
    send_tx(1, 0);
    check_tx(1, "R4 start after busy");
  endtask

  task automatic t_tx_busy_mid;
    txq[0] = 8'h12; txq[1] = 8'hF0; txq[2] = 8'h9B;
    send_tx(3, 1);
    check_tx(3, "R5 busy mid-frame");
    busy_in = 0;
    repeat (4) @(negedge tx_clk);
  endtask

  task automatic t_tx_out_mode;
    busy_is_out = 1; busy_in = 1;
    repeat (4) @(negedge tx_clk);
    chk(busy_oe && tx_ready, "R6 busy_in ignored", {busy_oe, tx_ready}, 3);
    txq[0] = 8'hC3;
    send_tx(1, 0);
    check_tx(1, "R6 frame in out mode");
    busy_in = 0; busy_is_out = 0;
    @(negedge tx_clk);
    chk(!busy_oe, "R6 oe follows config", busy_oe, 0);
  endtask

  task automatic t_collision;
    col_in = 1;
    repeat (4) @(negedge tx_clk);
    chk(!tx_ready && !ser_txen, "R8 collision gates start", {tx_ready, ser_txen}, 0);
    chk(col_sticky, "R7 sticky set", col_sticky, 1);
    col_in = 0;
    repeat (6) @(negedge sys_clk);
    chk(col_sticky, "R7 sticky holds", col_sticky, 1);
    col_clr = 1; @(negedge sys_clk); col_clr = 0;
    @(negedge sys_clk);
    chk(!col_sticky, "R7 sticky cleared", col_sticky, 0);
    repeat (4) @(negedge tx_clk);
    chk(tx_ready, "R8 ready after collision", tx_ready, 1);
  endtask

  task automatic t_rx_frames;
    rxq[0] = 8'h6D; rxq[1] = 8'hB2;
    rx_send(2, 0);
    rxq[0] = 8'h0F;
    rx_send(1, 0);
    pop_check(8'h6D, 0, 0, "R9 first byte");
    pop_check(8'hB2, 1, 0, "R9 last byte");
    pop_check(8'h0F, 1, 0, "R12 next frame order");
  endtask

  task automatic t_rx_partial;
    rxq[0] = 8'hE4;
    rx_send(1, 3);
    pop_check(8'hE4, 0, 0, "R10 byte before partial");
    pop_check(8'h00, 1, 1, "R10 partial flagged");
    rx_send(0, 5);
    pop_check(8'h00, 1, 1, "R10 partial-only frame");
  endtask

  task automatic t_rx_full;
    busy_is_out = 1;
    for (int i = 0; i < 9; i++) rxq[i] = 8'(8'h20 + i*3);
    rx_send(9, 0);
    repeat (6) @(negedge rx_clk);
    chk(busy_out && busy_oe, "R11 busy when full", {busy_out, busy_oe}, 3);
    for (int i = 0; i < 8; i++) pop_check(rxq[i], 0, 0, "R11 kept entries");
    repeat (8) @(negedge sys_clk);
    chk(!rx_valid, "R11 overflow dropped", rx_valid, 0);
    repeat (6) @(negedge rx_clk);
    chk(!busy_out, "R11 busy released", busy_out, 0);
    busy_is_out = 0;
  endtask

  initial begin
    repeat (10) @(negedge sys_clk);
    rst_n = 1;
    repeat (4) @(negedge tx_clk);
    t_reset_state();
    t_tx_basic();
    t_tx_busy_gate();
    t_tx_busy_mid();
    t_tx_out_mode();
    t_collision();
    t_rx_frames();
    t_rx_partial();
    t_rx_full();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      done = 1;
      tests++; failed++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule